// File: doc/BRIEF.md
# Interleaved ADC Trigger Scheduler

This block sits between a single conversion-trigger source and up to four ADC cores that sample the same analog input. It passes each accepted trigger to exactly one core of a selected group. The group is worked through in turn, so the cores together give a sample stream faster than any one core can deliver. A 3-bit group code chooses which cores take part. The 2-bit resolution setting and the group together set the shortest gap allowed between accepted triggers. That gap is counted in ticks of the block clock. Normally one tick is half an ADC clock period (TAD). A mode input states instead that one tick is a whole TAD, and the gaps are then rounded up to whole TAD.

A trigger that comes before the gap has run out is dropped, and the block reports it with a one-cycle overrun pulse. When interleaving is off, every trigger goes to core 0 with no gap check. All outputs are registered and appear one clock after the trigger is sampled.

Top module: `ilv_trig_sched`

## Requirements
- R1: After reset, `core_start` and `overrun` are 0. The first accepted trigger goes to the lowest-numbered member of the selected group.
- R2: The group code in `grp_sel` sets the members as follows: 3'b100 selects cores {0,1}, 3'b001 selects {1,2}, 3'b101 selects {0,1,2}, 3'b010 selects {1,2,3} and 3'b011 selects {0,1,2,3}. A start strobe only ever goes to a member of the group.
- R3: The codes 3'b110 and 3'b111 behave exactly like 3'b000.
- R4: When interleaving is off (3'b000), every trigger strobes core 0 (`core_start` = 4'b0001). No gap check is made and `overrun` is never raised.
- R5: Accepted triggers go to the members in ascending core order and wrap from the highest member back to the lowest.
- R6: With `full_tad`=0, the minimum gap in ticks is indexed by `res_sel` (0=12 bit, 1=10 bit, 2=8 bit, 3=6 bit). {1,2}: 16,14,12,9. {0,1}: 20,17,15,13. {0,1,2}: 13,12,10,9. {1,2,3}: 11,10,8,6. {0,1,2,3}: 10,9,8,7. A trigger whose gap from the last accepted trigger is at least this value is accepted.
- R7: With `full_tad`=1, the minimum gap in ticks is the R6 value divided by two and rounded up.
- R8: A trigger that comes before the gap has run out strobes no core and does not advance the rotation. It raises `overrun` for one cycle. The gap is still measured from the last accepted trigger.
- R9: A change of group (where R3 codes count as one and the same off group), or a cycle with `enable` low, sends the rotation back to the lowest member. It also clears the gap history, so the next trigger is accepted.
- R10: While `enable` is 0, triggers are ignored: no strobe and no overrun.
- R11: A trigger sampled on a rising edge gives its result one cycle later. At most one `core_start` bit is high in a cycle, and that never happens in the same cycle as `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (half-TAD or whole-TAD ticks) |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable |
| trig_in | input | 1 | Shared conversion trigger, one tick per trigger |
| grp_sel | input | 3 | Interleave group code |
| res_sel | input | 2 | Resolution: 0=12, 1=10, 2=8, 3=6 bit |
| full_tad | input | 1 | 1: one tick equals one TAD; gaps rounded up |
| core_start | output | 4 | One-cycle start strobe per core |
| overrun | output | 1 | One-cycle pulse for a dropped early trigger |

## Verification
For every group, resolution and tick mode, the bench places a trigger one tick short of the minimum gap and then one exactly at it. A table entry that is off by one tick would either drop the legal trigger or pass the early one. A design that restarted the gap count on a dropped trigger would reject the trigger placed at the full gap from the last accepted one. Mid-rotation group switches and enable drops catch a pointer that is not reset, because the next strobe would land on the wrong core. Reserved codes fed with back-to-back triggers expose any decoder that treats them as a real group.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

   localparam int NUM_CORES = 4;
   localparam int IDX_W     = 2;

   typedef enum logic [2:0] {
      GRP_OFF,
      GRP_12,
      GRP_01,
      GRP_012,
      GRP_123,
      GRP_0123
   } grp_e;

   typedef enum logic [1:0] {
      RES_12 = 2'd0,
      RES_10 = 2'd1,
      RES_8  = 2'd2,
      RES_6  = 2'd3
   } res_e;

   function automatic grp_e decode_group(input logic [2:0] code);
      grp_e g;
      case (code)
         3'b100:  g = GRP_01;
         3'b001:  g = GRP_12;
         3'b101:  g = GRP_012;
         3'b010:  g = GRP_123;
         3'b011:  g = GRP_0123;
         default: g = GRP_OFF;
      endcase
      return g;
   endfunction

   function automatic logic [NUM_CORES-1:0] group_mask(input grp_e g);
      logic [NUM_CORES-1:0] m;
      case (g)
         GRP_01:   m = 4'b0011;
         GRP_12:   m = 4'b0110;
         GRP_012:  m = 4'b0111;
         GRP_123:  m = 4'b1110;
         GRP_0123: m = 4'b1111;
         default:  m = 4'b0001;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/ilv_member_map.sv
module ilv_member_map
   import ilv_pkg::*;
(
   input  grp_e                  grp,
   input  logic [IDX_W-1:0]      cur_idx,
   output logic [NUM_CORES-1:0]  mask,
   output logic [IDX_W-1:0]      lowest_idx,
   output logic [IDX_W-1:0]      next_idx
);

   always_comb begin
      mask = group_mask(grp);
   end

   always_comb begin
      lowest_idx = '0;
      for (int k = NUM_CORES - 1; k >= 0; k--) begin
         if (mask[k]) lowest_idx = IDX_W'(k);
      end
   end

   always_comb begin
      logic found;
      found    = 1'b0;
      next_idx = lowest_idx;
      for (int k = 1; k <= NUM_CORES; k++) begin
         logic [IDX_W-1:0] cand;
         cand = IDX_W'((int'(cur_idx) + k) % NUM_CORES);
         if (!found && mask[cand]) begin
            next_idx = cand;
            found    = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ilv_spacing_lut.sv
module ilv_spacing_lut
   import ilv_pkg::*;
#(
   parameter int CNT_W = 6
)(
   input  grp_e              grp,
   input  res_e              res,
   input  logic              full_tad,
   output logic [CNT_W-1:0]  min_gap
);

   localparam int HALF_W = 5;

   generate
      if (CNT_W < HALF_W) begin : g_bad_width
         $error("ilv_spacing_lut: CNT_W must be at least %0d", HALF_W);
      end
   endgenerate

   logic [HALF_W-1:0] half_ticks;
   logic [HALF_W-1:0] whole_ticks;

   always_comb begin
      half_ticks = '0;
      case (grp)
         GRP_12: begin
            case (res)
               RES_12: half_ticks = 5'd16;
               RES_10: half_ticks = 5'd14;
               RES_8:  half_ticks = 5'd12;
               default: half_ticks = 5'd9;
            endcase
         end
         GRP_01: begin
            case (res)
               RES_12: half_ticks = 5'd20;
               RES_10: half_ticks = 5'd17;
               RES_8:  half_ticks = 5'd15;
               default: half_ticks = 5'd13;
            endcase
         end
         GRP_012: begin
            case (res)
               RES_12: half_ticks = 5'd13;
               RES_10: half_ticks = 5'd12;
               RES_8:  half_ticks = 5'd10;
               default: half_ticks = 5'd9;
            endcase
         end
         GRP_123: begin
            case (res)
               RES_12: half_ticks = 5'd11;
               RES_10: half_ticks = 5'd10;
               RES_8:  half_ticks = 5'd8;
               default: half_ticks = 5'd6;
            endcase
         end
         GRP_0123: begin
            case (res)
               RES_12: half_ticks = 5'd10;
               RES_10: half_ticks = 5'd9;
               RES_8:  half_ticks = 5'd8;
               default: half_ticks = 5'd7;
            endcase
         end
         default: half_ticks = '0;
      endcase
   end

   always_comb begin
      whole_ticks = (half_ticks >> 1) + {{(HALF_W-1){1'b0}}, half_ticks[0]};
   end

   always_comb begin
      if (full_tad) min_gap = CNT_W'(whole_ticks);
      else          min_gap = CNT_W'(half_ticks);
   end

endmodule

// File: rtl/ilv_gap_timer.sv
module ilv_gap_timer #(
   parameter int CNT_W = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clear,
   output logic [CNT_W-1:0]  elapsed
);

   localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n)            elapsed <= SAT;
      else if (load)         elapsed <= CNT_W'(1);
      else if (clear)        elapsed <= SAT;
      else if (elapsed != SAT) elapsed <= elapsed + CNT_W'(1);
   end

   assert_elapsed_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      elapsed != '0);

endmodule

// File: rtl/ilv_trig_sched.sv
module ilv_trig_sched
   import ilv_pkg::*;
#(
   parameter int CNT_W = 6
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        enable,
   input  logic        trig_in,
   input  logic [2:0]  grp_sel,
   input  logic [1:0]  res_sel,
   input  logic        full_tad,
   output logic [3:0]  core_start,
   output logic        overrun
);

   generate
      if (NUM_CORES != 4) begin : g_bad_cores
         $error("ilv_trig_sched: group table assumes four cores");
      end
   endgenerate

   grp_e                  grp_now;
   grp_e                  grp_q;
   logic                  en_q;
   logic [IDX_W-1:0]      ptr_q;
   logic [IDX_W-1:0]      ptr_eff;
   logic [NUM_CORES-1:0]  mask_now;
   logic [IDX_W-1:0]      lowest_idx;
   logic [IDX_W-1:0]      next_idx;
   logic [CNT_W-1:0]      min_gap;
   logic [CNT_W-1:0]      elapsed;
   logic                  fresh;
   logic                  off_mode;
   logic                  gap_ok;
   logic                  accept;
   logic                  early;
   logic [NUM_CORES-1:0]  start_q;
   logic                  overrun_q;

   always_comb begin
      grp_now  = decode_group(grp_sel);
      off_mode = (grp_now == GRP_OFF);
      fresh    = (grp_now != grp_q) || !en_q;
      ptr_eff  = off_mode ? '0 : (fresh ? lowest_idx : ptr_q);
      gap_ok   = fresh || (elapsed >= min_gap);
      accept   = enable && trig_in && (off_mode || gap_ok);
      early    = enable && trig_in && !off_mode && !gap_ok;
   end

   ilv_member_map u_map (
      .grp        (grp_now),
      .cur_idx    (ptr_eff),
      .mask       (mask_now),
      .lowest_idx (lowest_idx),
      .next_idx   (next_idx)
   );

   ilv_spacing_lut #(.CNT_W(CNT_W)) u_lut (
      .grp      (grp_now),
      .res      (res_e'(res_sel)),
      .full_tad (full_tad),
      .min_gap  (min_gap)
   );

   ilv_gap_timer #(.CNT_W(CNT_W)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .clear   (!enable || (grp_now != grp_q)),
      .elapsed (elapsed)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_q <= GRP_OFF;
         en_q  <= 1'b0;
         ptr_q <= '0;
      end else begin
         grp_q <= grp_now;
         en_q  <= enable;
         if (accept)     ptr_q <= next_idx;
         else if (fresh) ptr_q <= lowest_idx;
      end
   end

   generate
      for (genvar c = 0; c < NUM_CORES; c++) begin : g_strobe
         always_ff @(posedge clk) begin
            if (!rst_n) start_q[c] <= 1'b0;
            else        start_q[c] <= accept && (ptr_eff == IDX_W'(c));
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) overrun_q <= 1'b0;
      else        overrun_q <= early;
   end

   assign core_start = start_q;
   assign overrun    = overrun_q;

   assert_onehot_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(core_start));

   assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(overrun && (core_start != '0)));

   assert_quiet_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (core_start == '0) && !overrun);

   assert_no_trig_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_in |=> (core_start == '0) && !overrun);

   assert_off_core0_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && trig_in && off_mode) |=> (core_start == 4'b0001) && !overrun);

   assert_member_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && trig_in) |=> ((core_start & ~$past(mask_now)) == '0));

endmodule

// File: tb/sim_ilv_trig_sched.sv
module sim_ilv_trig_sched;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       trig_in = 1'b0;
   logic [2:0] grp_sel = 3'b000;
   logic [1:0] res_sel = 2'd0;
   logic       full_tad = 1'b0;
   logic [3:0] core_start;
   logic       overrun;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [3:0] q_start[$];
   logic       q_ov[$];
   string      q_tag[$];

   // reference state
   logic [3:0] m_cls = 4'b0001;
   bit         m_en = 1'b0;
   int         m_ptr = 0;
   int         m_el = 1000;

   always #5 clk = ~clk;

   ilv_trig_sched u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .trig_in(trig_in),
      .grp_sel(grp_sel), .res_sel(res_sel), .full_tad(full_tad),
      .core_start(core_start), .overrun(overrun)
   );

   function automatic logic [3:0] ref_mask(input logic [2:0] code);
      case (code)
         3'b100: return 4'b0011;
         3'b001: return 4'b0110;
         3'b101: return 4'b0111;
         3'b010: return 4'b1110;
         3'b011: return 4'b1111;
         default: return 4'b0001;
      endcase
   endfunction

   function automatic int ref_half(input logic [2:0] code, input int r);
      int t[4];
      case (code)
         3'b001: t = '{16, 14, 12, 9};
         3'b100: t = '{20, 17, 15, 13};
         3'b101: t = '{13, 12, 10, 9};
         3'b010: t = '{11, 10, 8, 6};
         3'b011: t = '{10, 9, 8, 7};
         default: t = '{0, 0, 0, 0};
      endcase
      return t[r];
   endfunction

   function automatic int ref_gap(input logic [2:0] code, input int r, input bit whole);
      int h = ref_half(code, r);
      return whole ? (h + 1) / 2 : h;
   endfunction

   function automatic int lowest_of(input logic [3:0] m);
      for (int k = 0; k < 4; k++) if (m[k]) return k;
      return 0;
   endfunction

   function automatic int after(input logic [3:0] m, input int cur);
      for (int k = 1; k <= 4; k++) if (m[(cur + k) % 4]) return (cur + k) % 4;
      return cur;
   endfunction

   // monitor: compares one cycle after the inputs were sampled
   always @(posedge clk) begin
      #1;
      if (q_start.size() > 0) begin
         logic [3:0] es;
         logic       eo;
         string      tg;
         es = q_start.pop_front();
         eo = q_ov.pop_front();
         tg = q_tag.pop_front();
         n_cmp++;
         if (core_start !== es || overrun !== eo) begin
            n_bad++;
            $display("FAIL %s: core_start=%b overrun=%b expected core_start=%b overrun=%b",
                     tg, core_start, overrun, es, eo);
         end
      end
   end

   // driver: sets one cycle of inputs and queues the expected outcome
   task automatic drive(input bit en, input bit tr, input logic [2:0] code,
                        input int r, input bit whole, input string tag);
      logic [3:0] mk;
      logic [3:0] es;
      bit fr, ov, acc;
      int pe;
      @(negedge clk);
      enable = en; trig_in = tr; grp_sel = code; res_sel = 2'(r); full_tad = whole;
      mk = ref_mask(code);
      fr = (mk != m_cls) || !m_en;
      es = '0; ov = 1'b0; acc = 1'b0;
      pe = (mk == 4'b0001) ? 0 : (fr ? lowest_of(mk) : m_ptr);
      if (en && tr) begin
         if (mk == 4'b0001 || fr || m_el >= ref_gap(code, r, whole)) begin
            acc = 1'b1;
            es = 4'b0001 << pe;
         end else begin
            ov = 1'b1;
         end
      end
      if (acc)                         m_el = 1;
      else if (!en || mk != m_cls)     m_el = 1000;
      else if (m_el < 1000)            m_el++;
      if (acc)     m_ptr = after(mk, pe);
      else if (fr) m_ptr = lowest_of(mk);
      m_cls = mk;
      m_en  = en;
      q_start.push_back(es);
      q_ov.push_back(ov);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n, input logic [2:0] code, input int r, input bit whole,
                       input string tag);
      for (int i = 0; i < n; i++) drive(1'b1, 1'b0, code, r, whole, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs low while held in reset
      n_cmp++;
      if (core_start !== 4'b0 || overrun !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: core_start=%b overrun=%b expected 0000/0", core_start, overrun);
      end
      rst_n = 1'b1;

      // R1: first trigger after reset goes to lowest member
      drive(1'b1, 1'b1, 3'b010, 0, 1'b0, "R1");
      idle(12, 3'b010, 0, 1'b0, "R1");

      // R4: off mode, back-to-back triggers all to core 0
      for (int i = 0; i < 6; i++) drive(1'b1, 1'b1, 3'b000, 0, 1'b0, "R4");
      // R3: reserved codes behave as off
      for (int i = 0; i < 4; i++) drive(1'b1, 1'b1, 3'b110, 1, 1'b0, "R3");
      for (int i = 0; i < 4; i++) drive(1'b1, 1'b1, 3'b111, 3, 1'b0, "R3");

      // R5 / R2: rotation through every group at the legal gap
      foreach (ref_half_codes[gi]) begin
         logic [2:0] c;
         int g;
         c = ref_half_codes[gi];
         g = ref_gap(c, 0, 1'b0);
         for (int t = 0; t < 6; t++) begin
            drive(1'b1, 1'b1, c, 0, 1'b0, "R5");
            idle(g - 1, c, 0, 1'b0, "R2");
         end
      end

      // R6 / R7 / R8: early by one tick, then exactly at the gap
      for (int w = 0; w < 2; w++) begin
         foreach (ref_half_codes[gi]) begin
            for (int r = 0; r < 4; r++) begin
               logic [2:0] c;
               int g;
               string tg;
               c = ref_half_codes[gi];
               g = ref_gap(c, r, w[0]);
               tg = w ? "R7" : "R6";
               drive(1'b1, 1'b0, 3'b000, 0, w[0], "R9");
               drive(1'b1, 1'b1, c, r, w[0], tg);
               idle(g - 2, c, r, w[0], tg);
               drive(1'b1, 1'b1, c, r, w[0], "R8");
               drive(1'b1, 1'b1, c, r, w[0], tg);
               idle(g - 1, c, r, w[0], tg);
               drive(1'b1, 1'b1, c, r, w[0], tg);
               drive(1'b1, 1'b1, c, r, w[0], "R8");
               idle(2, c, r, w[0], "R8");
            end
         end
      end

      // R9: group change mid-rotation restarts at lowest member
      drive(1'b1, 1'b1, 3'b011, 3, 1'b0, "R9");
      idle(7, 3'b011, 3, 1'b0, "R9");
      drive(1'b1, 1'b1, 3'b011, 3, 1'b0, "R9");
      drive(1'b1, 1'b1, 3'b010, 3, 1'b0, "R9");
      drive(1'b1, 1'b1, 3'b101, 3, 1'b0, "R9");
      idle(9, 3'b101, 3, 1'b0, "R9");
      drive(1'b1, 1'b1, 3'b101, 3, 1'b0, "R9");
      // R10: triggers ignored while disabled; R9: restart after re-enable
      for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, 3'b101, 3, 1'b0, "R10");
      drive(1'b1, 1'b1, 3'b101, 3, 1'b0, "R9");
      drive(1'b1, 1'b1, 3'b101, 3, 1'b0, "R8");
      drive(1'b0, 1'b0, 3'b101, 3, 1'b0, "R10");
      drive(1'b1, 1'b1, 3'b101, 3, 1'b0, "R9");
      // R11: no trigger gives quiet outputs
      idle(5, 3'b011, 0, 1'b0, "R11");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   logic [2:0] ref_half_codes[5] = '{3'b001, 3'b100, 3'b101, 3'b010, 3'b011};

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run hung, got no end expected end");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule